// File: doc/BRIEF.md
# Receiver Configuration Register Bank with Soft Reset

This block holds the setup state of a digital receive signal processor. A host writes and reads it through a simple parallel port: a write strobe with address and data, and a read strobe whose data comes back one clock later. Fourteen word addresses starting at a base address form the window. Index 0 is the mode register. Indices 1 to 12 hold oscillator, gain, decimation and filter settings of assorted widths. Index 13 is reserved and always zero. All stored settings are packed onto one wide bus that feeds the datapath.

The active-low hard reset input passes through a synchronizer before it acts. While the synchronized reset is held, the block drives an accumulator clear strobe. When reset lifts, the block sits in soft reset, because bit 0 of the mode register comes up set. In soft reset, sample capture, processing, the parallel output drivers and the serial pin drivers are all disabled, and the synchronization role is forced to slave. Clearing bit 0 starts operation in the role chosen by mode bit 1. Setting bit 0 again returns the block to soft reset without losing any settings.

Only a subset of registers is meant to change while the block is running. A write to any other register while running still takes effect, but it also sets a sticky warning flag.

Top module: `rxcfg_regbank`

## Requirements
- R1: After the hard reset releases, `soft_rst` is 1, `static_wr` is 0, the mode register (index 0) reads 0x1, and every other register reads 0.
- R2: While the synchronized hard reset is held, `accum_clr` is 1. It returns to 0 within three cycles after `hard_rst_n` goes high.
- R3: While mode bit 0 is 1, the registered outputs `capture_en`, `proc_en`, `out_drive_en`, `serial_drive_en` and `sync_master` are all 0 on the next cycle, whatever the value of mode bit 1.
- R4: When a write clears mode bit 0, all four enables are 1 from the cycle after the write. `sync_master` then equals mode bit 1, where 1 selects master and 0 selects slave.
- R5: Writing 1 to mode bit 0 while running re-enters soft reset, and the enables fall on the next cycle. All other register contents are kept.
- R6: A read strobe gives `rd_valid` on the next cycle. `rd_data` then holds the register truncated to its width and zero-extended: index 7 is 5 bits wide and index 4 is 16 bits wide.
- R7: Addresses outside the 14-word window read as 0. Writes to them change no register and do not set the flag.
- R8: The reserved register at index 13 always reads 0, and writes to it are ignored.
- R9: While running, writes to indices 0, 2, 3, 4, 5, 7, 9 and 11 are stored, and `static_wr` stays 0.
- R10: While running, a write to index 1, 6, 8, 10 or 12 is stored and sets `static_wr`. The flag stays set through soft reset entry and is cleared only by a hard reset.
- R11: While in soft reset, writes to any window register except index 13 are stored without setting `static_wr`.
- R12: `cfg_bus` packs the registers in index order, starting with index 0 at bit 0. Each register takes exactly its own width: index 2 occupies bits 47:16 and the mode register occupies bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Active-low hard reset, synchronized inside the block |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW (10) | Word address |
| wr_data | input | DW (32) | Write data |
| rd_data | output | DW (32) | Read data, valid the cycle after `rd_en` |
| rd_valid | output | 1 | Read data valid |
| soft_rst | output | 1 | Soft reset state (mode bit 0) |
| accum_clr | output | 1 | Clear strobe for the accumulators and the phase accumulator |
| capture_en | output | 1 | Input sample capture enable |
| proc_en | output | 1 | Processing enable |
| out_drive_en | output | 1 | Parallel output pin drive enable |
| serial_drive_en | output | 1 | Serial pin drive enable |
| sync_master | output | 1 | 1 = synchronization master, 0 = slave |
| static_wr | output | 1 | Sticky flag: a setup-only register was written while running |
| cfg_bus | output | CFG_W (153) | All stored settings, packed by index |

## Verification
The bench aims at the edges of the soft reset state. It sets the master role while soft reset is still held, and a design that failed to force slave would then drive `sync_master` early. It writes setup registers both during soft reset and while running, which exposes a flag that fires in the wrong state or clears on soft reset entry. It writes all-ones to narrow registers and probes the reserved word and out-of-window addresses, so a missing width mask or a loose address decode would show up in the read data. A second hard reset checks that the flag and the stored values both return to zero.

// File: rtl/rxcfg_pkg.sv
package rxcfg_pkg;

  localparam int NREG = 14;
  localparam int RSV  = NREG - 1;

  function automatic int reg_width(input int i);
    case (i)
      0, 1, 5, 6, 8, 10, 11, 12: return 8;
      2, 3:                     return 32;
      4:                        return 16;
      7:                        return 5;
      9:                        return 4;
      default:                  return 0;
    endcase
  endfunction

  function automatic int reg_offset(input int i);
    int s;
    s = 0;
    for (int j = 0; j < i; j++) s += reg_width(j);
    return s;
  endfunction

  // registers that may be changed while the datapath runs
  function automatic bit is_live(input int i);
    case (i)
      0, 2, 3, 4, 5, 7, 9, 11: return 1'b1;
      default:                 return 1'b0;
    endcase
  endfunction

  localparam int CFG_W = reg_offset(RSV);

endpackage

// File: rtl/rxcfg_rst_sync.sv
module rxcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_out,
  output logic clr_out
);
  logic [STAGES-1:0] chain;
  logic              clr_q;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], rst_n_in};
    clr_q <= ~chain[STAGES-1];
  end

  assign rst_out = ~chain[STAGES-1];
  assign clr_out = clr_q;
endmodule

// File: rtl/rxcfg_regs.sv
module rxcfg_regs
  import rxcfg_pkg::*;
#(
  parameter int          AW   = 10,
  parameter int          DW   = 32,
  parameter logic [AW-1:0] BASE = 10'h300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             static_wr,
  output logic [CFG_W-1:0] cfg_bus
);
  localparam int IW = $clog2(NREG);

  logic [AW-1:0] off;
  logic          in_win;
  logic [IW-1:0] idx;
  logic          soft_now;
  logic          wr_hit;
  logic [DW-1:0] rd_vals [NREG];
  logic [DW-1:0] rd_q;
  logic          rv_q;
  logic          flag_q;

  always_comb begin
    off    = addr - BASE;
    in_win = (addr >= BASE) && (off < AW'(NREG));
    idx    = off[IW-1:0];
    wr_hit = wr_en && in_win && (idx != IW'(RSV));
  end

  assign soft_now = cfg_bus[0];

  for (genvar i = 0; i < RSV; i++) begin : g_reg
    localparam int W = reg_width(i);
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= W'(i == 0);
      else if (wr_hit && idx == IW'(i))
        q <= wr_data[W-1:0];
    end
    assign rd_vals[i] = DW'(q);
    assign cfg_bus[reg_offset(i) +: W] = q;
  end

  assign rd_vals[RSV] = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= '0;
      rv_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rv_q <= rd_en;
      if (rd_en) rd_q <= in_win ? rd_vals[idx] : '0;
      if (wr_hit && !soft_now && !is_live(int'(idx)))
        flag_q <= 1'b1;
    end
  end

  assign rd_data   = rd_q;
  assign rd_valid  = rv_q;
  assign static_wr = flag_q;
endmodule

// File: rtl/rxcfg_gate.sv
module rxcfg_gate (
  input  logic clk,
  input  logic rst,
  input  logic soft_rst,
  input  logic role_sel,
  output logic capture_en,
  output logic proc_en,
  output logic out_drive_en,
  output logic serial_drive_en,
  output logic sync_master
);
  logic run;
  assign run = ~soft_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      capture_en      <= 1'b0;
      proc_en         <= 1'b0;
      out_drive_en    <= 1'b0;
      serial_drive_en <= 1'b0;
      sync_master     <= 1'b0;
    end else begin
      capture_en      <= run;
      proc_en         <= run;
      out_drive_en    <= run;
      serial_drive_en <= run;
      sync_master     <= run & role_sel;
    end
  end
endmodule

// File: rtl/rxcfg_regbank.sv
module rxcfg_regbank
  import rxcfg_pkg::*;
#(
  parameter int            AW          = 10,
  parameter int            DW          = 32,
  parameter logic [AW-1:0] BASE        = 10'h300,
  parameter int            SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             hard_rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             soft_rst,
  output logic             accum_clr,
  output logic             capture_en,
  output logic             proc_en,
  output logic             out_drive_en,
  output logic             serial_drive_en,
  output logic             sync_master,
  output logic             static_wr,
  output logic [CFG_W-1:0] cfg_bus
);
  logic rst_int;

  rxcfg_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n_in (hard_rst_n),
    .rst_out  (rst_int),
    .clr_out  (accum_clr)
  );

  rxcfg_regs #(.AW(AW), .DW(DW), .BASE(BASE)) u_regs (
    .clk       (clk),
    .rst       (rst_int),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .static_wr (static_wr),
    .cfg_bus   (cfg_bus)
  );

  assign soft_rst = cfg_bus[0];

  rxcfg_gate u_gate (
    .clk             (clk),
    .rst             (rst_int),
    .soft_rst        (cfg_bus[0]),
    .role_sel        (cfg_bus[1]),
    .capture_en      (capture_en),
    .proc_en         (proc_en),
    .out_drive_en    (out_drive_en),
    .serial_drive_en (serial_drive_en),
    .sync_master     (sync_master)
  );
endmodule

// File: rtl/rxcfg_checker.sv
module rxcfg_checker #(
  parameter int            AW   = 10,
  parameter int            DW   = 32,
  parameter logic [AW-1:0] BASE = 10'h300
) (
  input logic          clk,
  input logic          rst,
  input logic          soft_rst,
  input logic          capture_en,
  input logic          proc_en,
  input logic          out_drive_en,
  input logic          serial_drive_en,
  input logic          sync_master,
  input logic          static_wr,
  input logic          rd_en,
  input logic          rd_valid,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rd_data
);
  localparam logic [AW-1:0] RSV_ADDR = BASE + AW'(rxcfg_pkg::RSV);

  a_r1_boot_soft: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> soft_rst && !static_wr);

  a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !capture_en && !proc_en && !out_drive_en && !serial_drive_en && !sync_master);

  a_r4_running: assert property (@(posedge clk) disable iff (rst)
    !soft_rst |=> capture_en && proc_en && out_drive_en && serial_drive_en);

  a_r6_rd_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en) && $past(addr) == RSV_ADDR |-> rd_data == '0);

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    static_wr |=> static_wr);
endmodule

bind rxcfg_regbank rxcfg_checker #(.AW(AW), .DW(DW), .BASE(BASE)) u_chk (
  .clk             (clk),
  .rst             (rst_int),
  .soft_rst        (soft_rst),
  .capture_en      (capture_en),
  .proc_en         (proc_en),
  .out_drive_en    (out_drive_en),
  .serial_drive_en (serial_drive_en),
  .sync_master     (sync_master),
  .static_wr       (static_wr),
  .rd_en           (rd_en),
  .rd_valid        (rd_valid),
  .addr            (addr),
  .rd_data         (rd_data)
);

// File: tb/tb_rxcfg_regbank.sv
module tb_rxcfg_regbank;
  localparam int CW = rxcfg_pkg::CFG_W;

  logic          clk = 1'b0;
  logic          hard_rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic          rd_valid, soft_rst, accum_clr, capture_en, proc_en;
  logic          out_drive_en, serial_drive_en, sync_master, static_wr;
  logic [CW-1:0] cfg_bus;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  typedef struct {
    logic [31:0] exp;
    logic [9:0]  a;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  rxcfg_regbank dut (
    .clk(clk), .hard_rst_n(hard_rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .soft_rst(soft_rst), .accum_clr(accum_clr), .capture_en(capture_en),
    .proc_en(proc_en), .out_drive_en(out_drive_en),
    .serial_drive_en(serial_drive_en), .sync_master(sync_master),
    .static_wr(static_wr), .cfg_bus(cfg_bus)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.a = a; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops expected read results
  always @(negedge clk) begin
    if (rd_valid) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 unexpected rd_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check($sformatf("%s read 0x%0h", e.tag, e.a), 64'(rd_data), 64'(e.exp));
      end
    end
  end

  task automatic check_gates(input string tag, input logic run, input logic master);
    check({tag, " capture_en"}, 64'(capture_en), 64'(run));
    check({tag, " proc_en"}, 64'(proc_en), 64'(run));
    check({tag, " out_drive_en"}, 64'(out_drive_en), 64'(run));
    check({tag, " serial_drive_en"}, 64'(serial_drive_en), 64'(run));
    check({tag, " sync_master"}, 64'(sync_master), 64'(master));
  endtask

  task automatic hard_reset();
    @(negedge clk);
    hard_rst_n = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 accum_clr during reset", 64'(accum_clr), 64'd1);
    hard_rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 accum_clr after release", 64'(accum_clr), 64'd0);
  endtask

  initial begin
    hard_reset();
    // R1 boot state
    check("R1 soft_rst", 64'(soft_rst), 64'd1);
    check("R1 static_wr", 64'(static_wr), 64'd0);
    check_gates("R1/R3 boot", 1'b0, 1'b0);
    rd(10'h300, 32'h1, "R1");
    rd(10'h301, 32'h0, "R1");
    rd(10'h30C, 32'h0, "R1");
    rd(10'h303, 32'h0, "R1");

    // R11 setup writes during soft reset
    wr(10'h301, 32'hA5);
    check("R11 static_wr after setup write", 64'(static_wr), 64'd0);
    rd(10'h301, 32'hA5, "R11");

    // R3 master role requested but soft reset still set
    wr(10'h300, 32'h3);
    @(negedge clk);
    check_gates("R3 held", 1'b0, 1'b0);

    // R6 width truncation
    wr(10'h307, 32'hFFFF_FFFF);
    rd(10'h307, 32'h1F, "R6");
    wr(10'h304, 32'h1234_5678);
    rd(10'h304, 32'h5678, "R6");

    // R12 packed bus
    wr(10'h302, 32'hDEAD_BEEF);
    check("R12 cfg_bus index2", 64'(cfg_bus[47:16]), 64'hDEAD_BEEF);
    check("R12 cfg_bus mode", 64'(cfg_bus[7:0]), 64'h3);

    // R4 release as master, then slave
    wr(10'h300, 32'h2);
    @(negedge clk);
    check("R4 soft_rst", 64'(soft_rst), 64'd0);
    check_gates("R4 master", 1'b1, 1'b1);
    wr(10'h300, 32'h0);
    @(negedge clk);
    check_gates("R4 slave", 1'b1, 1'b0);

    // R9 live writes while running
    wr(10'h303, 32'h1111_2222);
    wr(10'h309, 32'hFF);
    check("R9 static_wr", 64'(static_wr), 64'd0);
    rd(10'h303, 32'h1111_2222, "R9");
    rd(10'h309, 32'hF, "R9");

    // R7 outside window
    wr(10'h30E, 32'hFF);
    wr(10'h2FF, 32'hFF);
    check("R7 static_wr", 64'(static_wr), 64'd0);
    rd(10'h30E, 32'h0, "R7");
    rd(10'h2FF, 32'h0, "R7");
    rd(10'h301, 32'hA5, "R7");

    // R8 reserved word
    wr(10'h30D, 32'h7);
    check("R8 static_wr", 64'(static_wr), 64'd0);
    rd(10'h30D, 32'h0, "R8");

    // R10 setup write while running
    wr(10'h30A, 32'h1F);
    check("R10 static_wr set", 64'(static_wr), 64'd1);
    rd(10'h30A, 32'h1F, "R10");

    // R5 re-enter soft reset
    wr(10'h300, 32'h3);
    @(negedge clk);
    check("R5 soft_rst", 64'(soft_rst), 64'd1);
    check_gates("R5 frozen", 1'b0, 1'b0);
    check("R10 static_wr sticky", 64'(static_wr), 64'd1);
    rd(10'h303, 32'h1111_2222, "R5");
    rd(10'h304, 32'h5678, "R5");

    repeat (3) @(negedge clk);
    // second hard reset clears everything
    hard_reset();
    check("R10 static_wr cleared", 64'(static_wr), 64'd0);
    rd(10'h303, 32'h0, "R1");
    rd(10'h300, 32'h1, "R1");

    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", 64'(sb.size()), 64'd0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule